// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands over N clock cycles with a single N-bit adder. A 2N-bit accumulator holds the partial sum in its upper half and the not-yet-consumed multiplier bits in its lower half. In each cycle the accumulator's least significant bit decides whether the multiplicand is added into the upper half. The whole accumulator then moves right by one place, so each multiplier bit leaves as soon as it has been used.

A caller raises `start` for one cycle while the unit is idle; the operands are captured on that edge. `busy` stays high for the N working cycles, after which `done` pulses for one cycle and `product` holds the full 2N-bit result until the next accepted start. A start presented while the unit is working is dropped.

Top module: `shiftadd_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: For any unsigned operands, `product` equals `mcand_in * mplier_in`, both taken at the accepted start, as a full 2N-bit value.
- R3: The carry out of each N-bit add is kept, so the largest operands ((2^N-1) times (2^N-1)) give the exact full-width result with no lost bits.
- R4: If a start is accepted at clock edge k, `busy` is 1 after edges k+1 through k+N-1 and also just after edge k, it falls after edge k+N, and `done` is 1 for exactly the one cycle following edge k+N.
- R5: A `start` sampled while `busy` is 1, including on the final working cycle, is ignored: the running result and its timing are unchanged.
- R6: While idle with `start` low, `product` stays constant and `done` stays 0, regardless of the operand inputs.
- R7: A `start` sampled in the same cycle that `done` is 1 is accepted and begins a new multiplication.
- R8: A zero in either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin; taken only when idle |
| mcand_in | input | N | Multiplicand operand |
| mplier_in | input | N | Multiplier operand |
| busy | output | 1 | High while the N iterations run |
| done | output | 1 | One-cycle pulse when `product` becomes valid |
| product | output | 2N | Full unsigned product |

## Verification
Two events can share a cycle: the completion pulse and a new request. A request can also arrive on the final iteration, while the unit still reports busy. The bench raises `start` in the very cycle `done` is high and expects a fresh run with the new operands. It also raises `start` on the last working cycle and in the middle of a run, with different operands, and expects that request to have no effect on either the finishing result or the done timing.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

endpackage

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic last_step,
  output logic busy,
  output logic done
);
  import shiftadd_pkg::*;

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  phase_t        phase_q;
  logic [CW-1:0] iter_q;
  logic          done_q;

  assign busy      = (phase_q == PH_RUN);
  assign accept    = start && !busy;
  assign step      = busy;
  assign last_step = busy && (iter_q == LAST);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (accept) begin
        phase_q <= PH_RUN;
        iter_q  <= '0;
      end else if (last_step) begin
        phase_q <= PH_IDLE;
      end else if (step) begin
        iter_q <= iter_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/shiftadd_dp.sv
module shiftadd_dp #(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [N-1:0]   mcand_in,
  input  logic [N-1:0]   mplier_in,
  output logic           add_now,
  output logic [2*N-1:0] acc
);
  localparam int W = 2 * N;

  logic [N-1:0] mcand_q;
  logic [W-1:0] acc_q;
  logic [N:0]   upper_sum;

  function automatic logic [N:0] upper_add(input logic [N-1:0] hi,
                                           input logic [N-1:0] m,
                                           input logic         en);
    logic [N:0] addend;
    addend = en ? {1'b0, m} : '0;
    return {1'b0, hi} + addend;
  endfunction

  assign add_now   = acc_q[0];
  assign upper_sum = upper_add(acc_q[W-1:N], mcand_q, add_now);
  assign acc       = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      acc_q   <= {{N{1'b0}}, mplier_in};
    end else if (step) begin
      acc_q <= {upper_sum, acc_q[N-1:1]};
    end
  end

endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand_in,
  input  logic [N-1:0]   mplier_in,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  logic accept;
  logic step;
  logic last_step;
  logic add_now;

  shiftadd_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .step      (step),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  shiftadd_dp #(.N(N)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .step      (step),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .add_now   (add_now),
    .acc       (product)
  );

endmodule

// File: rtl/shiftadd_mult_chk.sv
module shiftadd_mult_chk #(
  parameter int N = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N-1:0]   mcand_in,
  input logic [N-1:0]   mplier_in,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product,
  input logic           accept,
  input logic           last_step
);
  logic [2*N-1:0] want_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) want_q <= '0;
    else if (accept) want_q <= {{N{1'b0}}, mcand_in} * {{N{1'b0}}, mplier_in};
  end

  always_comb begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!busy && !done && product == '0);
    end
  end

  p_full_product_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == want_q);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done && !busy));

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> (busy && $stable(want_q)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(product) && !done));

  p_start_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy);

endmodule

bind shiftadd_mult shiftadd_mult_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mcand_in  (mcand_in),
  .mplier_in (mplier_in),
  .busy      (busy),
  .done      (done),
  .product   (product),
  .accept    (accept),
  .last_step (last_step)
);

// File: tb/shiftadd_mult_test.sv
module shiftadd_mult_test;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] mcand_in = '0;
  logic [N-1:0] mplier_in = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] product;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  shiftadd_mult #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand_in(mcand_in), .mplier_in(mplier_in),
    .busy(busy), .done(done), .product(product)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Offer start at the current negedge and run one operation.
  // mode 0: quiet, 1: stray start mid-run, 2: stray start on last cycle.
  task automatic run_one(input int a, input int b, input int mode, input string req);
    int expv;
    expv = a * b;
    start = 1'b1; mcand_in = N'(a); mplier_in = N'(b);
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      check(busy == 1'b1 && done == 1'b0, "R4", "busy window", int'(busy), 1);
      if ((mode == 1 && i == 2) || (mode == 2 && i == N)) begin
        start = 1'b1; mcand_in = ~N'(a); mplier_in = N'(b + 1);
      end else begin
        start = 1'b0; mcand_in = N'(b); mplier_in = N'(a + 3);
      end
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R4", "done pulse", int'(done), 1);
    check(int'(product) == expv, req, "product", int'(product), expv);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5;
    check(busy == 1'b0 && done == 1'b0, "R1", "reset flags", int'(busy), 0);
    check(product == '0, "R1", "reset product", int'(product), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(product == '0 && !busy, "R1", "after release", int'(product), 0);

    // R2 exhaustive sweep with idle gap between runs
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        run_one(a, b, 0, (a == 0 || b == 0) ? "R8" : "R2");
        @(negedge clk);
      end
    end

    // R3 maximum operands
    run_one((1 << N) - 1, (1 << N) - 1, 0, "R3");
    @(negedge clk);

    // R5 stray starts mid-run and on last cycle
    run_one(9, 13, 1, "R5");
    @(negedge clk);
    check(busy == 1'b0, "R5", "no restart after mid stray", int'(busy), 0);
    run_one(11, 7, 2, "R5");
    @(negedge clk);
    check(busy == 1'b0, "R5", "no restart after last stray", int'(busy), 0);

    // R6 idle hold with changing operands
    for (int k = 0; k < 4; k++) begin
      mcand_in = N'(k + 5); mplier_in = N'(k * 3);
      @(negedge clk);
      check(int'(product) == 77 && done == 1'b0, "R6", "idle hold",
            int'(product), 77);
    end

    // R7 back-to-back: start in the done cycle
    run_one(6, 14, 0, "R2");
    run_one(15, 3, 0, "R7");
    run_one(0, 12, 0, "R8");
    run_one(10, 10, 2, "R7");
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R4", "done one cycle", int'(done), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule